// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the state changes a processor core needs when it accepts an external interrupt request or executes a software-interrupt instruction. It is given the live status word, the address of the instruction in flight and the request lines. When it accepts an exception, it produces in one cycle everything the core's register file and status logic must write: the new privilege mode, the return address for the link register, the saved copy of the old status word, the rewritten status word and the vector address to fetch from next. It also raises a flush request for the fetch pipeline.

An accepted exception is committed in the cycle after the request is sampled. During that cycle `commit_o` and `flush_o` are high and all result outputs are valid. In the cycle after that, `busy_o` is high while the pipeline refills. The sequencer accepts a new exception only when it is neither committing nor busy. The interface has no data stream: the requests and strobes are plain control pins with no back-pressure. The interrupt request is a level and is re-evaluated each time the sequencer is idle. The software-interrupt request is a one-cycle strobe. If that strobe arrives while the sequencer cannot take it, the sequencer holds it until it can.

Status word layout: bits [4:0] hold the mode, bit 5 is the instruction-state bit (1 = 16-bit instructions, 0 = 32-bit), and bit 7 is the interrupt-disable bit.

Top module: `exc_entry_seq`

## Requirements
- R1: While status bit 7 (interrupt disable) is 1, an interrupt request is ignored and produces no commit.
- R2: On interrupt entry, `lr_o` equals `pc_i` minus the instruction width plus 4. The width is 4 when status bit 5 is 0 and 2 when it is 1.
- R3: On software-interrupt entry, `lr_o` equals `pc_i` minus the instruction width, using the same width rule as R2.
- R4: Interrupt entry gives `mode_o` = 5'h12 and `vec_o` = 32'h18. Software-interrupt entry gives `mode_o` = 5'h13 and `vec_o` = 32'h08.
- R5: `spsr_o` equals the status word present when the request was accepted.
- R6: `stat_o` equals the accepted status word with bits [4:0] replaced by the new mode, bit 5 cleared and bit 7 set. All other bits are unchanged.
- R7: A request sampled at a clock edge while idle produces `commit_o` = `flush_o` = 1 for the following cycle. `busy_o` = 1 for the cycle after that. No new commit occurs in either of those cycles.
- R8: When both requests are present in the same cycle, the software interrupt is committed first. An interrupt that is still requested and still unmasked is committed as soon as the sequencer is idle again.
- R9: A software-interrupt strobe that arrives during a commit or busy cycle is held, and it is committed once the sequencer is idle.
- R10: After reset, `commit_o`, `flush_o`, `busy_o` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| irq_req_i | input | 1 | Interrupt request (level) |
| swi_req_i | input | 1 | Software-interrupt request (one-cycle strobe) |
| commit_o | output | 1 | Write strobe for mode, link, status, saved status and PC |
| flush_o | output | 1 | Pipeline flush request |
| busy_o | output | 1 | Flush cycle in progress; no entry accepted |
| mode_o | output | 5 | New privilege mode |
| lr_o | output | 32 | Return address for the link register |
| vec_o | output | 32 | New program counter (vector) |
| spsr_o | output | 32 | Value for the saved status register |
| stat_o | output | 32 | New status word |

## Verification
A sequencer stuck outside idle would show up within two cycles: there would be no commit, or `busy_o` would stay high past its single cycle. A lost pending software interrupt would leave a gap where a commit should appear once the block returns to idle. A wrong priority or mask decision shows in the very cycle of the commit, as the wrong pairing of `mode_o` and `vec_o` or as a commit where none was due. A wrong width selection shows immediately as a return address that is off by two.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MODE_W = 5;
  localparam int T_BIT  = 5;
  localparam int I_BIT  = 7;

  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;

  typedef enum logic [1:0] {ST_IDLE, ST_COMMIT, ST_FLUSH} seq_state_e;
  typedef enum logic {KIND_IRQ = 1'b0, KIND_SWI = 1'b1} exc_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle_i,
  input  logic      irq_req_i,
  input  logic      irq_mask_i,
  input  logic      swi_req_i,
  output logic      take_o,
  output exc_kind_e kind_o
);
  logic swi_pend_q;
  logic swi_any;
  logic take_swi;
  logic take_irq;

  assign swi_any  = swi_req_i | swi_pend_q;
  assign take_swi = idle_i & swi_any;
  assign take_irq = idle_i & ~swi_any & irq_req_i & ~irq_mask_i;
  assign take_o   = take_swi | take_irq;
  assign kind_o   = take_swi ? KIND_SWI : KIND_IRQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        swi_pend_q <= 1'b0;
    else if (take_swi) swi_pend_q <= 1'b0;
    else if (swi_req_i) swi_pend_q <= 1'b1;
  end

  // R1: a masked interrupt is never chosen
  a_r1_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o == KIND_IRQ) |-> !irq_mask_i);
  // R9: a strobe that cannot be taken is remembered
  a_r9_hold_swi: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_req_i && !idle_i) |=> swi_pend_q);
  // R8: the software interrupt wins a tie
  a_r8_swi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && swi_req_i && irq_req_i) |-> (take_o && kind_o == KIND_SWI));
endmodule

// File: rtl/exc_addr_calc.sv
module exc_addr_calc
  import exc_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] VEC_IRQ = 32'h18,
  parameter logic [31:0] VEC_SWI = 32'h08
) (
  input  exc_kind_e           kind_i,
  input  logic                thumb_i,
  input  logic [XLEN-1:0]     pc_i,
  output logic [XLEN-1:0]     lr_o,
  output logic [XLEN-1:0]     vec_o,
  output logic [MODE_W-1:0]   mode_o
);
  localparam logic [XLEN-1:0] WIDE   = XLEN'(4);
  localparam logic [XLEN-1:0] NARROW = XLEN'(2);

  logic [XLEN-1:0] width;
  logic [XLEN-1:0] back;

  assign width = thumb_i ? NARROW : WIDE;
  assign back  = pc_i - width;

  always_comb begin
    if (kind_i == KIND_SWI) begin
      lr_o   = back;
      vec_o  = XLEN'(VEC_SWI);
      mode_o = MODE_SVC;
    end else begin
      lr_o   = back + WIDE;
      vec_o  = XLEN'(VEC_IRQ);
      mode_o = MODE_IRQ;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          STAT_W  = 32,
  parameter logic [31:0] VEC_IRQ = 32'h18,
  parameter logic [31:0] VEC_SWI = 32'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              irq_req_i,
  input  logic              swi_req_i,
  output logic              commit_o,
  output logic              flush_o,
  output logic              busy_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [XLEN-1:0]   lr_o,
  output logic [XLEN-1:0]   vec_o,
  output logic [STAT_W-1:0] spsr_o,
  output logic [STAT_W-1:0] stat_o
);
  seq_state_e        state_q;
  logic              take;
  exc_kind_e         kind;
  logic [XLEN-1:0]   lr_n;
  logic [XLEN-1:0]   vec_n;
  logic [MODE_W-1:0] mode_n;
  logic [STAT_W-1:0] stat_n;

  exc_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (state_q == ST_IDLE),
    .irq_req_i (irq_req_i),
    .irq_mask_i(stat_i[I_BIT]),
    .swi_req_i (swi_req_i),
    .take_o    (take),
    .kind_o    (kind)
  );

  exc_addr_calc #(.XLEN(XLEN), .VEC_IRQ(VEC_IRQ), .VEC_SWI(VEC_SWI)) u_addr (
    .kind_i (kind),
    .thumb_i(stat_i[T_BIT]),
    .pc_i   (pc_i),
    .lr_o   (lr_n),
    .vec_o  (vec_n),
    .mode_o (mode_n)
  );

  always_comb begin
    stat_n               = stat_i;
    stat_n[MODE_W-1:0]   = mode_n;
    stat_n[T_BIT]        = 1'b0;
    stat_n[I_BIT]        = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_o  <= '0;
      lr_o    <= '0;
      vec_o   <= '0;
      spsr_o  <= '0;
      stat_o  <= '0;
    end else begin
      case (state_q)
        ST_IDLE:   if (take) state_q <= ST_COMMIT;
        ST_COMMIT: state_q <= ST_FLUSH;
        default:   state_q <= ST_IDLE;
      endcase
      if (take) begin
        mode_o <= mode_n;
        lr_o   <= lr_n;
        vec_o  <= vec_n;
        spsr_o <= stat_i;
        stat_o <= stat_n;
      end
    end
  end

  assign commit_o = (state_q == ST_COMMIT);
  assign flush_o  = commit_o;
  assign busy_o   = (state_q == ST_FLUSH);

  // R7: busy follows every commit, and no commit lands inside busy
  a_r7_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (busy_o && !commit_o));
  a_r7_quiet_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !commit_o);
  // R4: mode and vector belong to the same exception kind
  a_r4_mode_vec_pair: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ((mode_o == MODE_IRQ && vec_o == XLEN'(VEC_IRQ)) ||
                  (mode_o == MODE_SVC && vec_o == XLEN'(VEC_SWI))));
  // R6: new status carries the new mode, 32-bit state and the mask set
  a_r6_status_form: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (stat_o[MODE_W-1:0] == mode_o && !stat_o[T_BIT] && stat_o[I_BIT]));
  // R5: upper status bits pass through unchanged into both words
  a_r5_saved_upper: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (stat_o[STAT_W-1:I_BIT+1] == spsr_o[STAT_W-1:I_BIT+1]));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] stat_i = '0;
  logic [31:0] pc_i = '0;
  logic        irq_req_i = 1'b0;
  logic        swi_req_i = 1'b0;
  logic        commit_o, flush_o, busy_o;
  logic [4:0]  mode_o;
  logic [31:0] lr_o, vec_o, spsr_o, stat_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .pc_i(pc_i),
    .irq_req_i(irq_req_i), .swi_req_i(swi_req_i),
    .commit_o(commit_o), .flush_o(flush_o), .busy_o(busy_o),
    .mode_o(mode_o), .lr_o(lr_o), .vec_o(vec_o),
    .spsr_o(spsr_o), .stat_o(stat_o)
  );

  // entry: {is_swi, thumb, pc}
  localparam logic [33:0] TBL [6] = '{
    {1'b0, 1'b0, 32'h0000_1000},
    {1'b0, 1'b1, 32'h0000_2002},
    {1'b1, 1'b0, 32'h0800_0104},
    {1'b1, 1'b1, 32'h0300_0012},
    {1'b0, 1'b1, 32'hFFFF_FFFE},
    {1'b1, 1'b0, 32'h0000_0004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input logic [31:0] s, input logic [4:0] m);
    logic [31:0] r = s;
    r[4:0] = m;
    r[5] = 1'b0;
    r[7] = 1'b1;
    return r;
  endfunction

  task automatic check_entry(input string req, input bit is_swi, input logic [31:0] s,
                             input logic [31:0] pc);
    logic [31:0] w = s[5] ? 32'd2 : 32'd4;
    logic [4:0]  m = is_swi ? 5'h13 : 5'h12;
    chk({req, " commit"}, {31'd0, commit_o}, 32'd1);
    chk({req, " R7 flush"}, {31'd0, flush_o}, 32'd1);
    chk(is_swi ? {req, " R3 lr"} : {req, " R2 lr"}, lr_o, is_swi ? pc - w : pc - w + 32'd4);
    chk({req, " R4 vec"}, vec_o, is_swi ? 32'h08 : 32'h18);
    chk({req, " R4 mode"}, {27'd0, mode_o}, {27'd0, m});
    chk({req, " R5 spsr"}, spsr_o, s);
    chk({req, " R6 stat"}, stat_o, exp_stat(s, m));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 commit", {31'd0, commit_o}, 32'd0);
    chk("R10 busy", {31'd0, busy_o}, 32'd0);
    chk("R10 lr", lr_o, 32'd0);
    chk("R10 stat", stat_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      s = 32'hA000_001F | (32'(TBL[i][32]) << 5);
      stat_i = s;
      pc_i = TBL[i][31:0];
      swi_req_i = TBL[i][33];
      irq_req_i = ~TBL[i][33];
      @(negedge clk);
      swi_req_i = 1'b0;
      irq_req_i = 1'b0;
      check_entry("table", TBL[i][33], s, TBL[i][31:0]);
      @(negedge clk);
      chk("R7 busy", {31'd0, busy_o}, 32'd1);
      chk("R7 no commit in busy", {31'd0, commit_o}, 32'd0);
      @(negedge clk);
      chk("R7 idle", {31'd0, busy_o | commit_o}, 32'd0);
    end

    // R1: masked interrupt ignored
    stat_i = 32'h0000_009F;
    pc_i = 32'h100;
    irq_req_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 masked", {31'd0, commit_o | busy_o}, 32'd0);
    end
    irq_req_i = 1'b0;

    // R8: both at once, SWI first then IRQ retried
    s = 32'h0000_001F;
    stat_i = s;
    pc_i = 32'h400;
    irq_req_i = 1'b1;
    swi_req_i = 1'b1;
    @(negedge clk);
    swi_req_i = 1'b0;
    check_entry("R8 first", 1'b1, s, 32'h400);
    @(negedge clk);
    chk("R8 busy", {31'd0, busy_o}, 32'd1);
    @(negedge clk);
    chk("R8 idle gap", {31'd0, commit_o}, 32'd0);
    @(negedge clk);
    irq_req_i = 1'b0;
    check_entry("R8 retry", 1'b0, s, 32'h400);
    @(negedge clk);
    @(negedge clk);

    // R9: strobe during busy held and taken later
    s = 32'h0000_003F;
    stat_i = s;
    pc_i = 32'h800;
    irq_req_i = 1'b1;
    @(negedge clk);
    irq_req_i = 1'b0;
    check_entry("R9 irq", 1'b0, s, 32'h800);
    @(negedge clk);
    swi_req_i = 1'b1;
    @(negedge clk);
    swi_req_i = 1'b0;
    chk("R9 not yet", {31'd0, commit_o}, 32'd0);
    @(negedge clk);
    check_entry("R9 held", 1'b1, s, 32'h800);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule